// File: doc/BRIEF.md
# Miss-Delta Stride Prefetch Engine

This block watches the stream of cache-miss addresses, each tagged with a small context number. It looks for a constant distance between successive misses. Every accepted miss is reduced to its block address. The block then forms two deltas from a per-context history: the current block minus the previous miss, and the previous miss minus the one before it. When the two deltas are equal, the stride is taken as confirmed, and the block produces a burst of up to `DEGREE` prefetch candidates at `block + d*stride` for d = 1, 2, ... `DEGREE`. Every candidate carries the same fixed latency value as its delay.

Each context keeps its own pair of history registers. A configuration pin folds every request onto context 0 so that all requesters share one history. A second pin turns on a page guard. With the guard on, a burst ends at the first candidate whose page differs from the page of the triggering block. The candidates that are lost this way are added to a running drop counter. Candidates leave on a valid/ready handshake. A new miss is accepted only while no burst is in flight. Queueing and filtering of the candidates are left to the consumer.

Top module: `stride_prefetch_engine`

## Requirements
- R1: After reset `pf_valid` is 0, `miss_ready` is 1, `span_drop_cnt` is 0, and all history registers are cleared to zero.
- R2: A miss address is reduced to its block address by clearing its low log2(`BLK_BYTES`) bits (6 bits by default) before any delta is formed. Every emitted candidate has those bits at zero.
- R3: When the new delta differs from the old delta, no candidate is emitted. The history is still updated: the old last value becomes second-last, and the current block becomes last.
- R4: When the deltas match, the candidates `block + d*stride` appear in increasing order of d, from d = 1 to `DEGREE` (default 4). The stride may be negative (two's complement wrap at `ADDR_W` bits).
- R5: `pf_delay` equals `LATENCY` (default 20) on every emitted candidate.
- R6: With `ctx_sep_en`=1, each value of `miss_ctx` has its own history. Misses from one context do not affect the stride detection of another.
- R7: With `ctx_sep_en`=0, every miss uses the context 0 history, whatever `miss_ctx` carries.
- R8: With `page_stop_en`=1, the burst ends at the first candidate d whose address bits above log2(`PAGE_BYTES`) (bit 13 and up by default) differ from those of the triggering block. That candidate and all later ones are not emitted, and `span_drop_cnt` grows by `DEGREE - d + 1`.
- R9: With `page_stop_en`=0, candidates on other pages are emitted normally and `span_drop_cnt` does not change.
- R10: A zero stride is treated as confirmed like any other. From reset, a first miss to block 0 emits `DEGREE` copies of address 0.
- R11: `miss_ready` is 0 from the cycle after a burst is accepted until its last candidate is taken or the burst is cut. No miss is accepted in that span.
- R12: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctx_sep_en | input | 1 | 1: per-context history; 0: all misses use context 0 |
| page_stop_en | input | 1 | 1: cut a burst at the first page crossing |
| miss_valid | input | 1 | Miss address offered |
| miss_ready | output | 1 | Miss accepted when high together with `miss_valid` |
| miss_ctx | input | CTX_W (6) | Context number of the miss |
| miss_addr | input | ADDR_W (32) | Byte address of the miss |
| pf_valid | output | 1 | Prefetch candidate present |
| pf_ready | input | 1 | Consumer takes the candidate |
| pf_addr | output | ADDR_W (32) | Candidate block address |
| pf_delay | output | DELAY_W (16) | Delay attached to the candidate (`LATENCY`) |
| span_drop_cnt | output | SPAN_W (16) | Running count of candidates cut by the page guard |

## Verification
The detector is driven with miss streams that separate matching deltas from unequal ones. These include a positive stride, a negative stride and the zero stride left by reset, which shows that equality alone triggers a burst. Streams from two contexts are interleaved under both settings of `ctx_sep_en`. One interleaving must show independent detection and the other must show a shared history. Page-guard cases cut a burst at its first and at its second candidate, which checks the drop arithmetic. The same crossing with the guard off shows the candidates passing through. A consumer that stalls in the middle of a burst exercises the holding of the candidate and the blocking of new misses.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

endpackage

// File: rtl/spf_history.sv
module spf_history #(
  parameter int ADDR_W  = 32,
  parameter int NUM_CTX = 64,
  parameter int CTX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [CTX_W-1:0]  sel_ctx,
  input  logic [ADDR_W-1:0] cur_blk,
  output logic [ADDR_W-1:0] last_q,
  output logic [ADDR_W-1:0] prev_q
);

  logic [ADDR_W-1:0] last_r [NUM_CTX];
  logic [ADDR_W-1:0] prev_r [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic hit_en;
    assign hit_en = upd_en && (sel_ctx == CTX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_r[g] <= '0;
        prev_r[g] <= '0;
      end else if (hit_en) begin
        prev_r[g] <= last_r[g];
        last_r[g] <= cur_blk;
      end
    end
  end

  assign last_q = last_r[sel_ctx];
  assign prev_q = prev_r[sel_ctx];

endmodule

// File: rtl/spf_stride_cmp.sv
module spf_stride_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_blk,
  input  logic [ADDR_W-1:0] last_blk,
  input  logic [ADDR_W-1:0] prev_blk,
  output logic [ADDR_W-1:0] new_stride,
  output logic              stride_match
);

  logic [ADDR_W-1:0] old_stride;

  always_comb begin
    new_stride   = cur_blk - last_blk;
    old_stride   = last_blk - prev_blk;
    stride_match = (new_stride == old_stride);
  end

endmodule

// File: rtl/spf_burst_gen.sv
module spf_burst_gen
  import spf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DEGREE    = 4,
  parameter int PAGE_BITS = 13,
  parameter int DEG_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              page_stop_en_i,
  input  logic              pf_ready_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  output logic              busy_o,
  output logic              drop_en_o,
  output logic [DEG_W-1:0]  drop_amt_o
);

  gen_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [DEG_W-1:0]  d_q, d_d;
  logic [ADDR_W-1:0] page_diff;
  logic              crossed;
  logic              reg_en;

  always_comb begin
    page_diff = (cur_q ^ base_q) >> PAGE_BITS;
    crossed   = page_stop_en_i && (|page_diff);
  end

  always_comb begin
    state_d    = state_q;
    base_d     = base_q;
    stride_d   = stride_q;
    cur_d      = cur_q;
    d_d        = d_q;
    drop_en_o  = 1'b0;
    drop_amt_o = DEG_W'(DEGREE) - d_q + DEG_W'(1);
    case (state_q)
      GEN_IDLE: begin
        if (load_i) begin
          state_d  = GEN_RUN;
          base_d   = base_i;
          stride_d = stride_i;
          cur_d    = base_i + stride_i;
          d_d      = DEG_W'(1);
        end
      end
      GEN_RUN: begin
        if (crossed) begin
          state_d   = GEN_IDLE;
          drop_en_o = 1'b1;
        end else if (pf_ready_i) begin
          if (d_q == DEG_W'(DEGREE)) begin
            state_d = GEN_IDLE;
          end else begin
            cur_d = cur_q + stride_q;
            d_d   = d_q + DEG_W'(1);
          end
        end
      end
      default: state_d = GEN_IDLE;
    endcase
  end

  assign reg_en = load_i || (state_q == GEN_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GEN_IDLE;
      base_q   <= '0;
      stride_q <= '0;
      cur_q    <= '0;
      d_q      <= '0;
    end else if (reg_en) begin
      state_q  <= state_d;
      base_q   <= base_d;
      stride_q <= stride_d;
      cur_q    <= cur_d;
      d_q      <= d_d;
    end
  end

  assign busy_o     = (state_q == GEN_RUN);
  assign pf_valid_o = busy_o && !crossed;
  assign pf_addr_o  = cur_q;

endmodule

// File: rtl/spf_drop_counter.sv
module spf_drop_counter #(
  parameter int SPAN_W = 16,
  parameter int DEG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [DEG_W-1:0]  add_val,
  output logic [SPAN_W-1:0] count_q
);

  logic [SPAN_W-1:0] count_d;

  always_comb begin
    count_d = count_q + SPAN_W'(add_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (add_en) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/stride_prefetch_engine.sv
module stride_prefetch_engine #(
  parameter int ADDR_W     = 32,
  parameter int NUM_CTX    = 64,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 8192,
  parameter int DEGREE     = 4,
  parameter int LATENCY    = 20,
  parameter int DELAY_W    = 16,
  parameter int SPAN_W     = 16,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctx_sep_en,
  input  logic               page_stop_en,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [CTX_W-1:0]   miss_ctx,
  input  logic [ADDR_W-1:0]  miss_addr,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [ADDR_W-1:0]  pf_addr,
  output logic [DELAY_W-1:0] pf_delay,
  output logic [SPAN_W-1:0]  span_drop_cnt
);

  localparam int BLK_BITS  = $clog2(BLK_BYTES);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int DEG_W     = $clog2(DEGREE + 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((64'd1 << BLK_BITS) - 64'd1);

  logic              rst_meta_q, rst_sync_n;
  logic [ADDR_W-1:0] cur_blk;
  logic [CTX_W-1:0]  eff_ctx;
  logic              accept;
  logic [ADDR_W-1:0] last_blk, prev_blk, new_stride;
  logic              stride_match;
  logic              gen_busy;
  logic              drop_en;
  logic [DEG_W-1:0]  drop_amt;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    cur_blk    = miss_addr & ~BLK_MASK;
    eff_ctx    = ctx_sep_en ? miss_ctx : '0;
    miss_ready = !gen_busy;
    accept     = miss_valid && miss_ready;
  end

  spf_history #(
    .ADDR_W (ADDR_W),
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W)
  ) hist_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (accept),
    .sel_ctx(eff_ctx),
    .cur_blk(cur_blk),
    .last_q (last_blk),
    .prev_q (prev_blk)
  );

  spf_stride_cmp #(
    .ADDR_W(ADDR_W)
  ) cmp_i (
    .cur_blk     (cur_blk),
    .last_blk    (last_blk),
    .prev_blk    (prev_blk),
    .new_stride  (new_stride),
    .stride_match(stride_match)
  );

  spf_burst_gen #(
    .ADDR_W   (ADDR_W),
    .DEGREE   (DEGREE),
    .PAGE_BITS(PAGE_BITS),
    .DEG_W    (DEG_W)
  ) gen_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .load_i        (accept && stride_match),
    .base_i        (cur_blk),
    .stride_i      (new_stride),
    .page_stop_en_i(page_stop_en),
    .pf_ready_i    (pf_ready),
    .pf_valid_o    (pf_valid),
    .pf_addr_o     (pf_addr),
    .busy_o        (gen_busy),
    .drop_en_o     (drop_en),
    .drop_amt_o    (drop_amt)
  );

  spf_drop_counter #(
    .SPAN_W(SPAN_W),
    .DEG_W (DEG_W)
  ) drop_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .add_en (drop_en),
    .add_val(drop_amt),
    .count_q(span_drop_cnt)
  );

  assign pf_delay = DELAY_W'(LATENCY);

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W   = 32,
  parameter int BLK_BITS = 6,
  parameter int SPAN_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_stop_en,
  input logic              miss_ready,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [SPAN_W-1:0] span_drop_cnt
);

  // R1: quiet outputs on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pf_valid && miss_ready && span_drop_cnt == '0));

  // R2: candidates are block aligned
  a_r2_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[BLK_BITS-1:0] == '0));

  // R4: consecutive candidates of one burst are an equal step apart
  a_r4_constant_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pf_valid && pf_ready, 2) && $past(pf_valid && pf_ready) && pf_valid)
    |-> ((pf_addr - $past(pf_addr)) == ($past(pf_addr) - $past(pf_addr, 2))));

  // R9: no drop counting with the page guard off
  a_r9_no_drop_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    !page_stop_en |=> $stable(span_drop_cnt));

  // R11: no miss accepted while a candidate is pending
  a_r11_busy_blocks_miss: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !miss_ready);

  // R12: a stalled candidate is held
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

endmodule

bind stride_prefetch_engine spf_checker #(
  .ADDR_W  (ADDR_W),
  .BLK_BITS($clog2(BLK_BYTES)),
  .SPAN_W  (SPAN_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .page_stop_en (page_stop_en),
  .miss_ready   (miss_ready),
  .pf_valid     (pf_valid),
  .pf_ready     (pf_ready),
  .pf_addr      (pf_addr),
  .span_drop_cnt(span_drop_cnt)
);

// File: tb/stride_prefetch_engine_tb_top.sv
`timescale 1ns/1ps
module stride_prefetch_engine_tb_top;

  localparam int DEG = 4;
  localparam int LAT = 20;
  localparam int NV  = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctx_sep_en, page_stop_en;
  logic        miss_valid, miss_ready;
  logic [5:0]  miss_ctx;
  logic [31:0] miss_addr;
  logic        pf_valid, pf_ready;
  logic [31:0] pf_addr;
  logic [15:0] pf_delay;
  logic [15:0] span_drop_cnt;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  stride_prefetch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctx_sep_en(ctx_sep_en), .page_stop_en(page_stop_en),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_ctx(miss_ctx),
    .miss_addr(miss_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .pf_delay(pf_delay), .span_drop_cnt(span_drop_cnt)
  );

  // {tag[3:0], sep, stop, ctx[5:0], addr[31:0]}
  localparam logic [43:0] VECS [NV] = '{
    {4'd10, 1'b1, 1'b1, 6'd0,  32'h0000_0010}, // R10 zero stride from reset
    {4'd3,  1'b1, 1'b1, 6'd0,  32'h0000_1000}, // R3
    {4'd3,  1'b1, 1'b1, 6'd0,  32'h0000_1040}, // R3
    {4'd2,  1'b1, 1'b1, 6'd0,  32'h0000_10A5}, // R2 / R4
    {4'd6,  1'b1, 1'b1, 6'd5,  32'h0000_5000}, // R6
    {4'd6,  1'b1, 1'b1, 6'd0,  32'h0000_10C0}, // R6
    {4'd6,  1'b1, 1'b1, 6'd5,  32'h0000_4F00}, // R6
    {4'd4,  1'b1, 1'b1, 6'd5,  32'h0000_4E00}, // R4 negative
    {4'd8,  1'b1, 1'b1, 6'd10, 32'h0000_1C80}, // R8
    {4'd8,  1'b1, 1'b1, 6'd10, 32'h0000_1D80}, // R8
    {4'd8,  1'b1, 1'b1, 6'd10, 32'h0000_1E80}, // R8 cut at d=2
    {4'd8,  1'b1, 1'b1, 6'd9,  32'h0000_1D00}, // R8
    {4'd8,  1'b1, 1'b1, 6'd9,  32'h0000_1E00}, // R8
    {4'd8,  1'b1, 1'b1, 6'd9,  32'h0000_1F00}, // R8 cut at d=1
    {4'd9,  1'b1, 1'b0, 6'd11, 32'h0000_3F00}, // R9
    {4'd9,  1'b1, 1'b0, 6'd11, 32'h0000_3F40}, // R9
    {4'd9,  1'b1, 1'b0, 6'd11, 32'h0000_3F80}, // R9 crossing emitted
    {4'd7,  1'b0, 1'b1, 6'd7,  32'h0000_1100}, // R7 shared history
    {4'd7,  1'b0, 1'b1, 6'd3,  32'h0000_1140}  // R7
  };

  logic [31:0] m_last [64];
  logic [31:0] m_prev [64];
  logic [15:0] m_span;
  logic [31:0] exp_a [DEG];
  int          exp_n;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_last[i] = '0;
      m_prev[i] = '0;
    end
    m_span = '0;
  endtask

  task automatic model_miss(input bit sep, input bit stop, input logic [5:0] ctx,
                            input logic [31:0] addr);
    logic [31:0] blk, ns, os, a;
    int c;
    blk = addr & 32'hFFFF_FFC0;
    c = sep ? int'(ctx) : 0;
    ns = blk - m_last[c];
    os = m_last[c] - m_prev[c];
    m_prev[c] = m_last[c];
    m_last[c] = blk;
    exp_n = 0;
    if (ns == os) begin
      for (int d = 1; d <= DEG; d++) begin
        a = blk + 32'(d) * ns;
        if (stop && (a[31:13] != blk[31:13])) begin
          m_span = m_span + 16'(DEG - d + 1);
          break;
        end
        exp_a[exp_n] = a;
        exp_n++;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    miss_valid = 1'b0;
    pf_ready = 1'b1;
    ctx_sep_en = 1'b1;
    page_stop_en = 1'b1;
    miss_ctx = '0;
    miss_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic run_miss(input bit sep, input bit stop, input logic [5:0] ctx,
                          input logic [31:0] addr, input string tag, input int stall);
    int k;
    int guard;
    model_miss(sep, stop, ctx, addr);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    ctx_sep_en = sep;
    page_stop_en = stop;
    miss_ctx = ctx;
    miss_addr = addr;
    pf_ready = (stall == 0);
    miss_valid = 1'b1;
    @(posedge clk);
    #1 miss_valid = 1'b0;
    if (stall > 0) begin
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(pf_valid && pf_addr == exp_a[0], "R12", "stalled candidate", pf_addr, exp_a[0]);
        check(!miss_ready, "R11", "miss_ready during burst", 32'(miss_ready), 32'd0);
      end
      pf_ready = 1'b1;
    end else begin
      @(negedge clk);
    end
    k = 0;
    guard = 0;
    forever begin
      if (pf_valid) begin
        if (k < exp_n)
          check(pf_addr == exp_a[k], tag, "candidate address", pf_addr, exp_a[k]);
        else
          check(1'b0, tag, "unexpected candidate", pf_addr, 32'hFFFF_FFFF);
        check(pf_delay == 16'(LAT), "R5", "delay", 32'(pf_delay), 32'(LAT));
        k++;
      end
      if (!pf_valid && miss_ready) break;
      guard++;
      if (guard > 50) break;
      @(negedge clk);
    end
    check(k == exp_n, tag, "candidate count", 32'(k), 32'(exp_n));
    check(span_drop_cnt == m_span, tag, "drop count", 32'(span_drop_cnt), 32'(m_span));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(!pf_valid, "R1", "pf_valid after reset", 32'(pf_valid), 32'd0);
    check(miss_ready, "R1", "miss_ready after reset", 32'(miss_ready), 32'd1);
    check(span_drop_cnt == 0, "R1", "drop count after reset", 32'(span_drop_cnt), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_miss(VECS[i][39], VECS[i][38], VECS[i][37:32], VECS[i][31:0],
               $sformatf("R%0d", VECS[i][43:40]), 0);
    end

    // R12 / R11: stalled consumer mid-burst
    run_miss(1'b1, 1'b1, 6'd12, 32'h0000_8000, "R3", 0);
    run_miss(1'b1, 1'b1, 6'd12, 32'h0000_8080, "R3", 0);
    run_miss(1'b1, 1'b1, 6'd12, 32'h0000_8100, "R12", 3);

    // R1: a second reset clears history and drop count; zero stride emits again (R10)
    do_reset();
    check(span_drop_cnt == 0, "R1", "drop count after second reset", 32'(span_drop_cnt), 32'd0);
    run_miss(1'b1, 1'b1, 6'd0, 32'h0000_003F, "R10", 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule